// File: doc/BRIEF.md
# Wide-to-Narrow Burst Bus Bridge

The bridge connects a 128-bit internal data path to a 16-bit external memory bus. A requester issues one access at a time: an instruction fetch, which is either a cache fill or a plain fetch, or a data read or write of 16 or 32 bits. The bridge then runs the access on the external bus as a sequence of halfword beats. Each beat has an address phase followed by a data phase that lasts until the external side signals ready.

Every access goes through a 128-bit staging buffer of eight halfword lanes. Read beats are packed into the lane selected by the beat address. When the last beat completes, the bridge returns the whole line for a fetch, or the addressed 32-bit or 16-bit slice for a data read. For a write, the data is placed in the buffer when the request is accepted and then sent out one lane per beat. Halfwords use big-endian order: a lower address holds more significant bits.

Top module: `burst_bridge`

## Requirements
- R1: A fetch with req_fill_i=1 runs exactly 8 read beats, starting at the 16-byte line base (address bits [3:0] zero), whatever the low address bits are.
- R2: A fetch with req_fill_i=0 starts at the request address with bits [1:0] cleared and runs 8 - 2*addr[3:2] beats, so it ends at the end of the 16-byte line. Lanes the burst does not reach read as zero in rdata_o.
- R3: Beat i of a burst drives ext_addr_o = start address + 2*i. Bits [31:4] stay equal to those of the request throughout the burst.
- R4: A 32-bit read (req_kind_i=2'b01, or the reserved 2'b11, with req_wide_i=1) runs 2 beats from addr with bits [1:0] cleared. rdata_o[31:16] returns the first beat and rdata_o[15:0] the second, with rdata_o[127:32] zero.
- R5: A 32-bit write (req_kind_i=2'b10, req_wide_i=1) runs 2 beats with ext_we_o=1 during each data phase. The first beat drives req_wdata_i[31:16] and the second drives req_wdata_i[15:0].
- R6: A 16-bit access (req_wide_i=0) runs a single beat at addr with bit 0 cleared. A read returns the halfword in rdata_o[15:0] with all other bits zero, and a write drives req_wdata_i[15:0].
- R7: Each beat asserts ext_as_o for exactly one cycle, then holds ext_ds_o until a cycle in which ext_ready_i=1. The two strobes are never high together, and ext_addr_o is stable across the data phase.
- R8: done_o pulses for exactly one cycle, in the cycle after the last beat's ready. req_ready_o is 1 only when idle. A request presented while busy is ignored and does not start a later burst.
- R9: In a fetch result, the halfword at line byte offset 2*j appears at rdata_o[127-16*j -: 16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_kind_i | input | 2 | 00 fetch, 01 data read, 10 data write, 11 treated as data read |
| req_fill_i | input | 1 | Fetch is a cache-line fill |
| req_wide_i | input | 1 | Data access is 32 bits (else 16) |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 128 | Read result, valid with done_o |
| ext_addr_o | output | 32 | External beat address |
| ext_as_o | output | 1 | Address-phase strobe |
| ext_ds_o | output | 1 | Data-phase strobe |
| ext_we_o | output | 1 | Write direction |
| ext_wdata_o | output | 16 | External write data |
| ext_rdata_i | input | 16 | External read data |
| ext_ready_i | input | 1 | Beat completes on this cycle |

## Verification
The bench checks plain fetches that start at every word of a line. A length rule that does not stop at the line end would issue beats in the next line, and one that does not reset to a full line would truncate. It runs fill fetches from an unaligned address, which catches a design that starts mid-line, and places 16-bit accesses in the last lane, where a wrong lane offset corrupts or moves the halfword. It varies the ready delay per beat, so a sequencer that skips the wait, or moves the address during the data phase, shows up. It also holds a foreign request for the whole of a burst, which exposes a block that accepts or queues requests while busy.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } seq_state_e;
endpackage

// File: rtl/bb_len_calc.sv
module bb_len_calc
  import bb_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BPW   = 2
) (
  input  acc_kind_e                       kind_i,
  input  logic                            fill_i,
  input  logic                            wide_i,
  input  logic [$clog2(LANES)-1:0]        lane_i,
  output logic [$clog2(LANES)-1:0]        start_lane_o,
  output logic [$clog2(LANES+1)-1:0]      nbeats_o
);
  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(LANES+1);

  logic [LW-1:0] aligned;
  assign aligned = lane_i & ~LW'(BPW-1);

  always_comb begin
    start_lane_o = lane_i;
    nbeats_o     = CW'(1);
    unique case (kind_i)
      ACC_FETCH: begin
        if (fill_i) begin
          start_lane_o = '0;
          nbeats_o     = CW'(LANES);
        end else begin
          // run to end of line, never past it
          start_lane_o = aligned;
          nbeats_o     = CW'(LANES) - CW'(aligned);
        end
      end
      default: begin
        if (wide_i) begin
          start_lane_o = aligned;
          nbeats_o     = CW'(BPW);
        end
      end
    endcase
  end

  always_comb begin
    a_len_range_r2: assert (nbeats_o != '0 && nbeats_o <= CW'(LANES))
      else $error("burst length out of range");
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] nbeats_i,
  input  logic          ready_i,
  output logic          idle_o,
  output logic          as_o,
  output logic          ds_o,
  output logic          cap_o,
  output logic          last_o,
  output logic [CW-1:0] beat_o,
  output logic          done_o
);
  seq_state_e    state_q;
  logic [CW-1:0] beat_q, n_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      n_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ADDR;
          beat_q  <= '0;
          n_q     <= nbeats_i;
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: if (ready_i) begin
          if (last_o) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            beat_q  <= beat_q + CW'(1);
            state_q <= ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign as_o   = (state_q == ST_ADDR);
  assign ds_o   = (state_q == ST_DATA);
  assign cap_o  = ds_o & ready_i;
  assign last_o = (beat_q == n_q - CW'(1));
  assign beat_o = beat_q;
  assign done_o = done_q;

  p_as_then_ds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |=> ds_o && !as_o);
  p_ds_waits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_o && !ready_i) |=> ds_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && last_o) |=> done_o && idle_o);
  p_beat_bounded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> beat_q < n_q);
endmodule

// File: rtl/bb_stage_buf.sv
module bb_stage_buf #(
  parameter int IW     = 128,
  parameter int EW     = 16,
  parameter int WORD_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic                          load_wide_i,
  input  logic [$clog2(IW/EW)-1:0]      load_lane_i,
  input  logic [WORD_W-1:0]             load_data_i,
  input  logic                          cap_i,
  input  logic [$clog2(IW/EW)-1:0]      cap_lane_i,
  input  logic [EW-1:0]                 cap_data_i,
  input  logic [$clog2(IW/EW)-1:0]      rd_lane_i,
  output logic [EW-1:0]                 rd_half_o,
  output logic [IW-1:0]                 buf_o
);
  localparam int LANES = IW / EW;
  localparam int LW    = $clog2(LANES);
  localparam int BPW   = WORD_W / EW;

  logic [EW-1:0] lanes_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < LANES; j++) lanes_q[j] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < LANES; j++) lanes_q[j] <= '0;
      if (load_wide_i) begin
        for (int m = 0; m < BPW; m++)
          lanes_q[load_lane_i + LW'(m)] <= load_data_i[WORD_W-1-EW*m -: EW];
      end else begin
        lanes_q[load_lane_i] <= load_data_i[EW-1:0];
      end
    end else if (cap_i) begin
      lanes_q[cap_lane_i] <= cap_data_i;
    end
  end

  // lane 0 (lowest address) sits in the most significant slot
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign buf_o[IW-1-EW*g -: EW] = lanes_q[g];
  end

  assign rd_half_o = lanes_q[rd_lane_i];
endmodule

// File: rtl/burst_bridge.sv
module burst_bridge
  import bb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IW     = 128,
  parameter int EW     = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_fill_i,
  input  logic              req_wide_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [IW-1:0]     rdata_o,
  output logic [AW-1:0]     ext_addr_o,
  output logic              ext_as_o,
  output logic              ext_ds_o,
  output logic              ext_we_o,
  output logic [EW-1:0]     ext_wdata_o,
  input  logic [EW-1:0]     ext_rdata_i,
  input  logic              ext_ready_i
);
  localparam int LANES     = IW / EW;
  localparam int LW        = $clog2(LANES);
  localparam int CW        = $clog2(LANES + 1);
  localparam int BYTE_OFF  = $clog2(EW / 8);
  localparam int LINE_BITS = LW + BYTE_OFF;
  localparam int BPW       = WORD_W / EW;

  acc_kind_e          kind_in, kind_q;
  logic [LW-1:0]      start_lane, start_lane_q, beat_lane;
  logic [CW-1:0]      nbeats, beat;
  logic [AW-LINE_BITS-1:0] line_q;
  logic               wide_q, accept, is_write_in;
  logic               idle, seq_cap, seq_last;
  logic [IW-1:0]      buf_w;
  logic               unused_bits;

  assign kind_in     = acc_kind_e'(req_kind_i);
  assign is_write_in = (kind_in == ACC_WRITE);
  assign accept      = req_valid_i & idle;
  assign unused_bits = ^{req_addr_i[BYTE_OFF-1:0], beat[CW-1]};

  bb_len_calc #(.LANES(LANES), .BPW(BPW)) u_len (
    .kind_i       (kind_in),
    .fill_i       (req_fill_i),
    .wide_i       (req_wide_i),
    .lane_i       (req_addr_i[LINE_BITS-1:BYTE_OFF]),
    .start_lane_o (start_lane),
    .nbeats_o     (nbeats)
  );

  bb_seq #(.CW(CW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .nbeats_i (nbeats),
    .ready_i  (ext_ready_i),
    .idle_o   (idle),
    .as_o     (ext_as_o),
    .ds_o     (ext_ds_o),
    .cap_o    (seq_cap),
    .last_o   (seq_last),
    .beat_o   (beat),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q       <= ACC_FETCH;
      wide_q       <= 1'b0;
      start_lane_q <= '0;
      line_q       <= '0;
    end else if (accept) begin
      kind_q       <= kind_in;
      wide_q       <= req_wide_i;
      start_lane_q <= start_lane;
      line_q       <= req_addr_i[AW-1:LINE_BITS];
    end
  end

  assign beat_lane = start_lane_q + beat[LW-1:0];

  bb_stage_buf #(.IW(IW), .EW(EW), .WORD_W(WORD_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_wide_i (req_wide_i),
    .load_lane_i (start_lane),
    .load_data_i (is_write_in ? req_wdata_i : '0),
    .cap_i       (seq_cap && kind_q != ACC_WRITE),
    .cap_lane_i  (beat_lane),
    .cap_data_i  (ext_rdata_i),
    .rd_lane_i   (beat_lane),
    .rd_half_o   (ext_wdata_o),
    .buf_o       (buf_w)
  );

  assign req_ready_o = idle;
  assign ext_addr_o  = {line_q, beat_lane, {BYTE_OFF{1'b0}}};
  assign ext_we_o    = !idle && (kind_q == ACC_WRITE);

  always_comb begin
    rdata_o = '0;
    if (kind_q == ACC_FETCH)
      rdata_o = buf_w;
    else if (wide_q)
      rdata_o[WORD_W-1:0] = buf_w[IW-1-EW*int'(start_lane_q) -: WORD_W];
    else
      rdata_o[EW-1:0] = buf_w[IW-1-EW*int'(start_lane_q) -: EW];
  end

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cap && !seq_last) |=> ext_as_o && ext_addr_o == $past(ext_addr_o) + AW'(EW/8));
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_ds_o && !ext_ready_i) |=> $stable(ext_addr_o));
  p_busy_no_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && req_valid_i) |=> $stable(line_q) && $stable(kind_q));
endmodule

// File: tb/burst_bridge_tb.sv
`timescale 1ns/1ps
module burst_bridge_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_kind = 2'b00;
  logic         req_fill = 1'b0;
  logic         req_wide = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready, done;
  logic [127:0] rdata;
  logic [31:0]  ext_addr;
  logic         ext_as, ext_ds, ext_we;
  logic [15:0]  ext_wdata;
  logic [15:0]  ext_rdata = '0;
  logic         ext_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_fill_i(req_fill),
    .req_wide_i(req_wide), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .done_o(done), .rdata_o(rdata),
    .ext_addr_o(ext_addr), .ext_as_o(ext_as), .ext_ds_o(ext_ds), .ext_we_o(ext_we),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata), .ext_ready_i(ext_ready)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem(input logic [31:0] a);
    return (a[15:0] * 16'd3) ^ 16'hC35A;
  endfunction

  task automatic run(input logic [1:0] kind, input logic fill, input logic wide,
                     input logic [31:0] addr, input logic [31:0] wd,
                     input int dly, input bit poke, input string rq);
    int start, n, ln, k;
    logic [127:0] eb, er;
    logic [31:0] a_exp;
    bit wr;
    wr = (kind == 2'b10);
    if (kind == 2'b00) begin
      if (fill) begin start = 0; n = 8; end
      else begin start = int'(addr[3:2]) * 2; n = 8 - start; end
    end else if (wide) begin start = int'(addr[3:2]) * 2; n = 2; end
    else begin start = int'(addr[3:1]); n = 1; end
    eb = '0;
    if (wr) begin
      if (wide) eb[127-16*start -: 32] = wd;
      else      eb[127-16*start -: 16] = wd[15:0];
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready while idle", 128'(req_ready), 128'd1);
    req_valid = 1'b1; req_kind = kind; req_fill = fill; req_wide = wide;
    req_addr = addr; req_wdata = wd;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      ext_ready = 1'b0;
      if (b == 0) begin
        if (poke) begin
          req_kind = 2'b10; req_addr = 32'h5555_5550; req_wdata = 32'h0;
        end else req_valid = 1'b0;
      end
      ln = start + b;
      a_exp = {addr[31:4], 4'(ln * 2)};
      chk(ext_as && !ext_ds, "R7", "address phase strobes", {ext_as, ext_ds}, 128'b10);
      chk(ext_addr == a_exp, rq, "R3 beat address", 128'(ext_addr), 128'(a_exp));
      chk(req_ready == 1'b0, "R8", "busy not ready", 128'(req_ready), 128'd0);
      k = (dly + b) % 3;
      for (int w = 0; w <= k; w++) begin
        @(negedge clk);
        chk(ext_ds && !ext_as, "R7", "data phase strobes", {ext_as, ext_ds}, 128'b01);
        chk(ext_addr == a_exp, "R7", "address held in data phase", 128'(ext_addr), 128'(a_exp));
        chk(ext_we == wr, rq, "write direction", 128'(ext_we), 128'(wr));
        if (wr)
          chk(ext_wdata == eb[127-16*ln -: 16], rq, "write beat data",
              128'(ext_wdata), 128'(eb[127-16*ln -: 16]));
        if (w == k) begin
          ext_ready = 1'b1;
          ext_rdata = mem(a_exp);
          if (!wr) eb[127-16*ln -: 16] = mem(a_exp);
          if (b == n - 1) req_valid = 1'b0;
        end
      end
    end
    @(negedge clk);
    ext_ready = 1'b0;
    chk(done == 1'b1, "R8", "done after last beat", 128'(done), 128'd1);
    chk(req_ready == 1'b1, "R8", "idle with done", 128'(req_ready), 128'd1);
    chk(!ext_as && !ext_ds, "R7", "no strobe after burst", {ext_as, ext_ds}, 128'd0);
    if (!wr) begin
      if (kind == 2'b00) er = eb;
      else if (wide) er = {96'd0, eb[127-16*start -: 32]};
      else er = {112'd0, eb[127-16*start -: 16]};
      chk(rdata == er, rq, "read result", rdata, er);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single pulse", 128'(done), 128'd0);
    chk(!ext_as, "R8", "no burst from busy request", 128'(ext_as), 128'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !ext_as && !ext_ds, "R8", "reset state",
        {req_ready, done, ext_as, ext_ds}, 128'b1000);
    // R1/R9: cache fill from an unaligned address
    run(2'b00, 1'b1, 1'b0, 32'h1000_0236, 32'h0, 0, 1'b0, "R1 R9");
    run(2'b00, 1'b1, 1'b0, 32'h2000_004F, 32'h0, 2, 1'b0, "R1");
    // R2: plain fetch from each word of the line
    run(2'b00, 1'b0, 1'b0, 32'h3000_0100, 32'h0, 1, 1'b0, "R2 R9");
    run(2'b00, 1'b0, 1'b0, 32'h3000_0106, 32'h0, 0, 1'b0, "R2");
    run(2'b00, 1'b0, 1'b0, 32'h3000_0108, 32'h0, 2, 1'b0, "R2");
    run(2'b00, 1'b0, 1'b0, 32'h3000_010D, 32'h0, 1, 1'b0, "R2");
    // R4: 32-bit reads, including reserved kind
    run(2'b01, 1'b0, 1'b1, 32'h4000_000A, 32'h0, 1, 1'b0, "R4");
    run(2'b11, 1'b0, 1'b1, 32'h4000_001C, 32'h0, 0, 1'b0, "R4");
    // R5: 32-bit writes
    run(2'b10, 1'b0, 1'b1, 32'h5000_0004, 32'hDEAD_BEEF, 2, 1'b0, "R5");
    run(2'b10, 1'b0, 1'b1, 32'h5000_000E, 32'h1234_5678, 0, 1'b0, "R5");
    // R6: 16-bit accesses, last lane and odd address
    run(2'b01, 1'b0, 1'b0, 32'h6000_000E, 32'h0, 1, 1'b0, "R6");
    run(2'b10, 1'b0, 1'b0, 32'h6000_0003, 32'hFFFF_A55A, 2, 1'b0, "R6");
    // R8: request held during a burst is ignored
    run(2'b00, 1'b0, 1'b0, 32'h7000_0008, 32'h0, 1, 1'b1, "R8");
    run(2'b01, 1'b0, 1'b1, 32'h7000_0000, 32'h0, 0, 1'b1, "R8");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule